// File: doc/BRIEF.md
# Pipelined Lane-Split Multi-Operand Adder

This block adds up to fifteen 16-bit operands into a single 16-bit word. Two runtime controls can cut the word into narrower lanes: one cut sits below bit 4 and one below bit 8. Each lane of the result holds the sum of the same lane across every operand. That sum wraps within the lane, and no carry crosses an active cut. A datapath uses it to fold many partial values at once. Examples are SIMD accumulation and the partial-product reduction of a multiplier. One operand count, fixed at elaboration, then serves whole words, byte pairs or nibble-and-wider layouts.

Inside, levels of 3:2 carry-save compressors shrink the operand set until two terms are left. A lane-aware ripple adder then resolves those two terms. A register point sits in front of every compression level and one sits after the final adder. A bit mask parameter turns each point into a flop stage or leaves it as a wire. The two cut controls travel through the same flops as the data they govern.

Top module: `pma_reduce_top`

## Requirements
- R1: With `N_IN` = 0 the operand bus is ignored and `sum_out` is always 0.
- R2: With `N_IN` = 1, `sum_out` equals the single operand, delayed by the configured latency.
- R3: With both cuts off, `sum_out` is the sum of all operands modulo 2^16. Operand n occupies `op_bus[16n+15:16n]`.
- R4: With only `cut_hi` set, bits [7:0] and bits [15:8] are each the lane sum of those bits across all operands, truncated to 8 bits.
- R5: With only `cut_lo` set, bits [3:0] are the 4-bit lane sum of the operands' bits [3:0], and bits [15:4] are the 12-bit lane sum of their bits [15:4].
- R6: With both cuts set, the three lanes [3:0], [7:4] and [15:8] are each summed independently and wrap within their own width.
- R7: The latency in clocks equals the number of set bits in `REG_MASK`. Bit k < D registers the terms in front of compression level k. Bit D registers the output. D is the tree depth for `N_IN`. After reset, every registered point holds zero, so `sum_out` is 0 until fresh data arrives.
- R8: Elaboration fails if `REG_MASK` has any bit set above bit D.
- R9: The cut controls are registered alongside the data. A cut setting that changes on every clock therefore still gives each result the lanes in force when its operands were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register points |
| rst | input | 1 | Synchronous active-high reset, clears every register point |
| op_bus | input | max(N_IN,1)*W | Packed operands, operand n in bits [W*n+W-1:W*n] |
| cut_lo | input | 1 | Splits the word below bit PT_LO (4) |
| cut_hi | input | 1 | Splits the word below bit PT_HI (8) |
| sum_out | output | W | Lane-wise sum of all operands |

## Verification
The bench builds five copies of the block. The first has seven operands and three register points spread through a four-level tree. The second has fifteen operands with no registers, which gives the deepest tree and the most carries landing on the cut bits. The third has one operand behind a single output register. The fourth has zero operands. The fifth has four operands with only the middle point registered. Together these cover both degenerate operand counts, latencies 0, 1 and 3, and registers placed before, between and after compression levels. The cut controls rotate through all four settings on every clock, so a cut that slips by one stage shows up at once. Saturated and alternating operand patterns drive a carry into every lane boundary.

// File: rtl/pma_pkg.sv
package pma_pkg;

   // terms left after one level of 3:2 compression
   function automatic int next_terms(input int t);
      return (t <= 2) ? t : (t / 3) * 2 + (t % 3);
   endfunction

   // term count entering compression level l
   function automatic int terms_at(input int n, input int l);
      int t;
      t = n;
      for (int i = 0; i < l; i++) t = next_terms(t);
      return t;
   endfunction

   // number of compression levels needed to reach two terms
   function automatic int tree_depth(input int n);
      int t;
      int d;
      t = n;
      d = 0;
      for (int i = 0; i < 32; i++) begin
         if (t > 2) begin
            t = next_terms(t);
            d++;
         end
      end
      return d;
   endfunction

   function automatic int popcount32(input logic [31:0] v);
      int c;
      c = 0;
      for (int i = 0; i < 32; i++) c += int'(v[i]);
      return c;
   endfunction

   // one-hot marks on the lowest bit of every lane opened by an active cut
   function automatic logic [31:0] lane_starts(input logic lo, input logic hi,
                                               input int pl, input int ph);
      logic [31:0] m;
      m = '0;
      m[pl] = lo;
      m[ph] = hi;
      return m;
   endfunction

endpackage

// File: rtl/pma_stage.sv
module pma_stage #(
   parameter int DW = 8,
   parameter bit EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   if (EN) begin : g_flop
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= d;
      end
   end else begin : g_wire
      assign q = d;
   end
endmodule

// File: rtl/pma_csa_level.sv
module pma_csa_level import pma_pkg::*; #(
   parameter int W     = 16,
   parameter int SLOTS = 7,
   parameter int N_T   = 7,
   parameter int PT_LO = 4,
   parameter int PT_HI = 8
) (
   input  logic                       cut_lo,
   input  logic                       cut_hi,
   input  logic [SLOTS-1:0][W-1:0]    terms_i,
   output logic [SLOTS-1:0][W-1:0]    terms_o
);
   localparam int GRP   = N_T / 3;
   localparam int REST  = N_T % 3;
   localparam int N_OUT = 2 * GRP + REST;

   logic [W-1:0] brk;
   assign brk = W'(lane_starts(cut_lo, cut_hi, PT_LO, PT_HI));

   for (genvar g = 0; g < GRP; g++) begin : g_csa
      logic [W-1:0] x, y, z, maj;
      assign x   = terms_i[3*g];
      assign y   = terms_i[3*g+1];
      assign z   = terms_i[3*g+2];
      assign maj = (x & y) | (x & z) | (y & z);
      assign terms_o[2*g]   = x ^ y ^ z;
      // carry moves up one bit and dies on the base bit of an open lane
      assign terms_o[2*g+1] = {maj[W-2:0], 1'b0} & ~brk;
   end

   for (genvar r = 0; r < REST; r++) begin : g_pass
      assign terms_o[2*GRP+r] = terms_i[3*GRP+r];
   end

   for (genvar k = N_OUT; k < SLOTS; k++) begin : g_zero
      assign terms_o[k] = '0;
   end
endmodule

// File: rtl/pma_lane_adder.sv
module pma_lane_adder import pma_pkg::*; #(
   parameter int W     = 16,
   parameter int PT_LO = 4,
   parameter int PT_HI = 8
) (
   input  logic         cut_lo,
   input  logic         cut_hi,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s
);
   logic [W-1:0] brk;
   assign brk = W'(lane_starts(cut_lo, cut_hi, PT_LO, PT_HI));

   always_comb begin
      logic c;
      logic cin;
      c = 1'b0;
      s = '0;
      for (int i = 0; i < W; i++) begin
         cin  = c & ~brk[i];
         s[i] = a[i] ^ b[i] ^ cin;
         c    = (a[i] & b[i]) | (a[i] & cin) | (b[i] & cin);
      end
   end
endmodule

// File: rtl/pma_reduce_top.sv
module pma_reduce_top import pma_pkg::*; #(
   parameter int          W        = 16,
   parameter int          N_IN     = 7,
   parameter int          PT_LO    = 4,
   parameter int          PT_HI    = 8,
   parameter logic [31:0] REG_MASK = 32'h0000_0015
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic [((N_IN < 1) ? 1 : N_IN)*W-1:0]  op_bus,
   input  logic                                  cut_lo,
   input  logic                                  cut_hi,
   output logic [W-1:0]                          sum_out
);
   localparam int SLOTS = (N_IN < 2) ? 2 : N_IN;
   localparam int DEPTH = tree_depth(N_IN);
   localparam int TW    = SLOTS * W;
   localparam int PW    = TW + 2;

   // elaboration-time parameter checks
   if (W < 2 || W > 32) begin : g_bad_w
      $error("pma_reduce_top: W must lie in 2..32");
   end
   if (PT_LO < 1 || PT_LO >= PT_HI || PT_HI >= W) begin : g_bad_pt
      $error("pma_reduce_top: need 0 < PT_LO < PT_HI < W");
   end
   if (N_IN < 0 || N_IN > 15) begin : g_bad_n
      $error("pma_reduce_top: N_IN must lie in 0..15");
   end
   if ((REG_MASK >> (DEPTH + 1)) != 32'd0) begin : g_bad_mask
      $error("pma_reduce_top: R8 REG_MASK names a point beyond the tree depth");
   end

   // xs[k]: bundle entering point k; ys[k]: bundle leaving it
   logic [PW-1:0] xs [0:DEPTH];
   logic [PW-1:0] ys [0:DEPTH];

   logic [SLOTS-1:0][W-1:0] in_terms;
   if (N_IN == 0) begin : g_empty
      assign in_terms = '0;
   end else if (N_IN == 1) begin : g_one
      assign in_terms = {{W{1'b0}}, op_bus[W-1:0]};
   end else begin : g_many
      assign in_terms = op_bus;
   end
   assign xs[0] = {cut_hi, cut_lo, in_terms};

   for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
      localparam int NT = terms_at(N_IN, k);
      logic [SLOTS-1:0][W-1:0] t_in, t_out;

      pma_stage #(.DW(PW), .EN(REG_MASK[k])) u_pt (
         .clk (clk),
         .rst (rst),
         .d   (xs[k]),
         .q   (ys[k])
      );

      assign t_in = ys[k][TW-1:0];

      pma_csa_level #(
         .W(W), .SLOTS(SLOTS), .N_T(NT), .PT_LO(PT_LO), .PT_HI(PT_HI)
      ) u_csa (
         .cut_lo  (ys[k][TW]),
         .cut_hi  (ys[k][TW+1]),
         .terms_i (t_in),
         .terms_o (t_out)
      );

      assign xs[k+1] = {ys[k][TW+1], ys[k][TW], t_out};
   end

   assign ys[DEPTH] = xs[DEPTH];

   // after the last level only slots 0 and 1 can be non-zero
   logic [SLOTS-1:0][W-1:0] fin_terms;
   logic [W-1:0]            fin_b;
   logic [W-1:0]            fin_sum;
   assign fin_terms = ys[DEPTH][TW-1:0];

   always_comb begin
      fin_b = '0;
      for (int s = 1; s < SLOTS; s++) fin_b |= fin_terms[s];
   end

   pma_lane_adder #(.W(W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_cpa (
      .cut_lo (ys[DEPTH][TW]),
      .cut_hi (ys[DEPTH][TW+1]),
      .a      (fin_terms[0]),
      .b      (fin_b),
      .s      (fin_sum)
   );

   pma_stage #(.DW(W), .EN(REG_MASK[DEPTH])) u_out (
      .clk (clk),
      .rst (rst),
      .d   (fin_sum),
      .q   (sum_out)
   );
endmodule

// File: rtl/pma_reduce_chk.sv
module pma_reduce_chk import pma_pkg::*; #(
   parameter int          W        = 16,
   parameter int          N_IN     = 7,
   parameter int          PT_LO    = 4,
   parameter int          PT_HI    = 8,
   parameter logic [31:0] REG_MASK = 32'h0000_0015
) (
   input logic                                  clk,
   input logic                                  rst,
   input logic [((N_IN < 1) ? 1 : N_IN)*W-1:0]  op_bus,
   input logic                                  cut_lo,
   input logic                                  cut_hi,
   input logic [W-1:0]                          sum_out
);
   localparam int OPW = ((N_IN < 1) ? 1 : N_IN) * W;
   localparam int LAT = popcount32(REG_MASK);

   // lane-by-lane sum of masked operand fields
   function automatic logic [W-1:0] lane_ref(input logic [OPW-1:0] ops,
                                             input logic lo, input logic hi);
      logic [W-1:0] res;
      longint       acc;
      int           st;
      res = '0;
      st  = 0;
      for (int e = 1; e <= W; e++) begin
         if (e == W || (lo && e == PT_LO) || (hi && e == PT_HI)) begin
            acc = 0;
            for (int n = 0; n < N_IN; n++)
               acc += longint'((ops[n*W +: W] >> st) & W'((64'd1 << (e - st)) - 1));
            for (int b = st; b < e; b++) res[b] = acc[b - st];
            st = e;
         end
      end
      return res;
   endfunction

   if (N_IN == 0) begin : g_r1
      a_r1_empty_is_zero: assert property (@(posedge clk) disable iff (rst)
         sum_out == '0);
   end

   if (N_IN == 1 && LAT == 0) begin : g_r2
      a_r2_single_passes: assert property (@(posedge clk) disable iff (rst)
         sum_out == op_bus[W-1:0]);
   end

   if (LAT == 0) begin : g_comb
      // R3 to R6: lane sums for every cut setting
      a_r3_lane_sum_comb: assert property (@(posedge clk) disable iff (rst)
         sum_out == lane_ref(op_bus, cut_lo, cut_hi));
   end

   if (LAT == 1) begin : g_one
      // R7 and R9: one clock later, lanes as they were when the operands arrived
      a_r9_lane_sum_delayed: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> sum_out == $past(lane_ref(op_bus, cut_lo, cut_hi)));
   end

   if (LAT > 0) begin : g_rst
      a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> sum_out == '0);
   end
endmodule

bind pma_reduce_top pma_reduce_chk #(
   .W(W), .N_IN(N_IN), .PT_LO(PT_LO), .PT_HI(PT_HI), .REG_MASK(REG_MASK)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .op_bus  (op_bus),
   .cut_lo  (cut_lo),
   .cut_hi  (cut_hi),
   .sum_out (sum_out)
);

// File: tb/test_pma_reduce_top.sv
module test_pma_reduce_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCYC       = 400;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [239:0] ops = '0;
   logic         c_lo = 1'b0;
   logic         c_hi = 1'b0;
   logic [15:0]  y_a, y_b, y_c, y_d, y_e;

   int checks = 0;
   int errors = 0;

   logic [239:0] h_ops [0:NCYC-1];
   logic         h_lo  [0:NCYC-1];
   logic         h_hi  [0:NCYC-1];

   always #(CLK_PERIOD/2) clk = ~clk;

   // A: 7 operands, points 0,2,4 -> latency 3
   pma_reduce_top #(.N_IN(7), .REG_MASK(32'h15)) i_pma_reduce_top (
      .clk(clk), .rst(rst), .op_bus(ops[111:0]), .cut_lo(c_lo), .cut_hi(c_hi), .sum_out(y_a));
   // B: 15 operands, purely combinational
   pma_reduce_top #(.N_IN(15), .REG_MASK(32'h0)) i_pma_reduce_top_b (
      .clk(clk), .rst(rst), .op_bus(ops), .cut_lo(c_lo), .cut_hi(c_hi), .sum_out(y_b));
   // C: 1 operand, output register -> latency 1
   pma_reduce_top #(.N_IN(1), .REG_MASK(32'h1)) i_pma_reduce_top_c (
      .clk(clk), .rst(rst), .op_bus(ops[15:0]), .cut_lo(c_lo), .cut_hi(c_hi), .sum_out(y_c));
   // D: no operands
   pma_reduce_top #(.N_IN(0), .REG_MASK(32'h0)) i_pma_reduce_top_d (
      .clk(clk), .rst(rst), .op_bus(ops[15:0]), .cut_lo(c_lo), .cut_hi(c_hi), .sum_out(y_d));
   // E: 4 operands, middle point only -> latency 1
   pma_reduce_top #(.N_IN(4), .REG_MASK(32'h2)) i_pma_reduce_top_e (
      .clk(clk), .rst(rst), .op_bus(ops[63:0]), .cut_lo(c_lo), .cut_hi(c_hi), .sum_out(y_e));

   // reference: lane masks per cut setting, straight from R3..R6
   function automatic logic [15:0] ref_sum(input logic [239:0] v, input int n,
                                           input logic lo, input logic hi);
      logic [15:0] m [0:2];
      int          nm;
      logic [15:0] y;
      int          acc;
      if (!lo && !hi)     begin m[0] = 16'hFFFF; nm = 1; end
      else if (!lo && hi) begin m[0] = 16'hFF00; m[1] = 16'h00FF; nm = 2; end
      else if (lo && !hi) begin m[0] = 16'hFFF0; m[1] = 16'h000F; nm = 2; end
      else begin m[0] = 16'hFF00; m[1] = 16'h00F0; m[2] = 16'h000F; nm = 3; end
      y = '0;
      for (int j = 0; j < nm; j++) begin
         acc = 0;
         for (int i = 0; i < n; i++) acc += int'(v[i*16 +: 16] & m[j]);
         y |= 16'(acc) & m[j];
      end
      return y;
   endfunction

   function automatic logic [15:0] exp_at(input int k, input int n, input int lat);
      if (k - lat < 0) return 16'h0;
      return ref_sum(h_ops[k-lat], n, h_lo[k-lat], h_hi[k-lat]);
   endfunction

   function automatic string mode_tag(input logic lo, input logic hi);
      if (!lo && !hi) return "R3";
      if (!lo && hi)  return "R4";
      if (lo && !hi)  return "R5";
      return "R6";
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [239:0] v;
      repeat (3) @(negedge clk);
      #1;
      chk("R7 reset A", y_a, 16'h0);
      chk("R7 reset C", y_c, 16'h0);
      chk("R7 reset E", y_e, 16'h0);
      chk("R1 reset D", y_d, 16'h0);
      rst = 1'b0;
      for (int k = 0; k < NCYC; k++) begin
         @(negedge clk);
         if (k < 8)       v = {15{16'hFFFF}};        // every lane saturated
         else if (k < 16) v = {15{16'h8888}};        // carries out of each nibble top
         else if (k < 24) v = {15{16'h0F0F}};
         else begin
            for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
         end
         h_ops[k] = v;
         h_lo[k]  = k[0];                            // R9: cuts change every clock
         h_hi[k]  = (k < 200) ? k[1] : k[2];
         ops  = v;
         c_lo = h_lo[k];
         c_hi = h_hi[k];
         #1;
         chk({mode_tag(h_lo[k], h_hi[k]), " B 15 ops"}, y_b, exp_at(k, 15, 0));
         chk("R1 D zero ops", y_d, 16'h0);
         if (k >= 3)
            chk({mode_tag(h_lo[k-3], h_hi[k-3]), "/R7/R9 A lat3"}, y_a, exp_at(k, 7, 3));
         else
            chk("R7 A after reset", y_a, 16'h0);
         chk("R2 C single op", y_c, (k >= 1) ? h_ops[k-1][15:0] : 16'h0);
         chk({mode_tag(k >= 1 ? h_lo[k-1] : 1'b0, k >= 1 ? h_hi[k-1] : 1'b0), "/R9 E lat1"},
             y_e, exp_at(k, 4, 1));
      end
      // R8 is an elaboration-time rule: every instance above sits within its depth
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule